// File: doc/BRIEF.md
# Read-Modify-Write Memory Sequencer

This block carries out the memory half of the in-place update instructions: increment, decrement, shift left, shift right, rotate left and rotate right. It is given an effective address and an operation code. It reads the target byte and writes that same byte back unchanged. It then computes the new value and writes it to the same address. As it finishes, it updates the carry, zero and negative flags. Address generation happens upstream; the block only runs the three bus cycles and the arithmetic.

When the accumulator form is selected, no bus cycle runs. The operation is applied to the accumulator value presented at the input, and the result appears on a registered accumulator output one cycle later.

The start strobe is a plain control pin, and there is no back-pressure at either edge. A start is taken only while the block is idle. The memory bus is single-port and takes one cycle per access. Read data is expected in the same cycle as the read strobe. The caller learns that a request has completed from the one-cycle `done` pulse.

Top module: `rmw_seq`

## Requirements
- R1: A start taken while idle with `acc_mode`=0 produces three consecutive bus cycles, beginning in the cycle after the start. The first is a read (`bus_re`=1). The second is a write of the byte just read. The third is a write of the modified byte. All three use the address latched at start.
- R2: `busy` is high during the three bus cycles. `done` is high for exactly one cycle, the cycle after the final write, with `busy` low.
- R3: The zero and negative flags are computed from the modified value (zero when it is 0x00, negative equal to its bit 7), never from the value read.
- R4: Op code 0 increments and op code 1 decrements, both modulo 256. Both leave carry equal to the `carry_in` captured at start.
- R5: Op code 2 shifts left and puts the old bit 7 into carry. Op code 3 shifts right and puts the old bit 0 into carry. Both fill the vacated bit with 0.
- R6: Op code 4 rotates left and op code 5 rotates right. The captured `carry_in` enters the vacated bit, and carry takes the bit shifted out (bit 7 for left, bit 0 for right).
- R7: A start taken while idle with `acc_mode`=1 performs no bus access. It applies the operation to `acc_in`. In the next cycle `acc_out` and the flags hold the result, and `done` is high.
- R8: A start raised while `busy` is high is ignored. A change of `op`, `addr_in`, `carry_in` or `acc_mode` during a sequence has no effect on that sequence or on `acc_out`.
- R9: Op codes 6 and 7 write back the original value as the modified value and leave carry equal to `carry_in`.
- R10: After reset, `busy`, `done`, `bus_we`, `bus_re`, `acc_out` and all flags are 0. The flags and `acc_out` change only on the cycle `done` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a request when idle |
| op | input | 3 | Operation code (0 inc, 1 dec, 2 shl, 3 shr, 4 rol, 5 ror) |
| acc_mode | input | 1 | 1 selects the accumulator form, which makes no bus access |
| addr_in | input | ADDR_W | Effective address of the target byte |
| acc_in | input | DATA_W | Accumulator value for the accumulator form |
| carry_in | input | 1 | Incoming carry |
| bus_addr | output | ADDR_W | Memory address |
| bus_rdata | input | DATA_W | Memory read data, valid in the read cycle |
| bus_wdata | output | DATA_W | Memory write data |
| bus_we | output | 1 | Memory write enable |
| bus_re | output | 1 | Memory read strobe |
| acc_out | output | DATA_W | Accumulator result register |
| busy | output | 1 | A memory sequence is in progress |
| done | output | 1 | One-cycle completion pulse |
| flag_c | output | 1 | Carry flag result |
| flag_z | output | 1 | Zero flag result |
| flag_n | output | 1 | Negative flag result |

## Verification
Every operation code is run on operands that sit on the edges that tell the operations apart:
- 0x7F and 0xFF for increment, which expose the sign change and the wrap to zero;
- 0x00 and 0x01 for decrement;
- bytes with bit 7 or bit 0 set for the shifts and rotates, with both carry values, so that the inserted carry and the ejected bit cannot be confused;
- the two spare codes, which must pass the byte through unchanged.

A read-back value that differs from the final one shows whether the dummy write carries the original byte. The accumulator form is run in both directions to confirm it stays off the bus. A run that disturbs every input mid-sequence shows whether the latched request is the one that executes.

// File: rtl/rmw_pkg.sv
package rmw_pkg;
  typedef enum logic [2:0] {
    OP_INC  = 3'd0,
    OP_DEC  = 3'd1,
    OP_SHL  = 3'd2,
    OP_SHR  = 3'd3,
    OP_ROL  = 3'd4,
    OP_ROR  = 3'd5,
    OP_SP6  = 3'd6,
    OP_SP7  = 3'd7
  } rmw_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_ECHO  = 2'd2,
    ST_FINAL = 2'd3
  } rmw_state_e;
endpackage

// File: rtl/rmw_alu.sv
module rmw_alu
  import rmw_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  rmw_op_e             op,
  input  logic [DATA_W-1:0]   val,
  input  logic                cin,
  output logic [DATA_W-1:0]   res,
  output logic                cout,
  output logic                zero,
  output logic                neg
);
  localparam int MSB = DATA_W - 1;

  always_comb begin
    res  = val;
    cout = cin;
    unique case (op)
      OP_INC: res = val + 1'b1;
      OP_DEC: res = val - 1'b1;
      OP_SHL: begin res = {val[MSB-1:0], 1'b0}; cout = val[MSB]; end
      OP_SHR: begin res = {1'b0, val[MSB:1]};   cout = val[0];   end
      OP_ROL: begin res = {val[MSB-1:0], cin};  cout = val[MSB]; end
      OP_ROR: begin res = {cin, val[MSB:1]};    cout = val[0];   end
      default: begin res = val; cout = cin; end
    endcase
  end

  assign zero = (res == '0);
  assign neg  = res[MSB];
endmodule

// File: rtl/rmw_fsm.sv
module rmw_fsm
  import rmw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic acc_mode,
  output logic idle,
  output logic load_mem,
  output logic load_acc,
  output logic rd_cyc,
  output logic echo_cyc,
  output logic final_cyc,
  output logic done
);
  rmw_state_e state_q;

  assign idle      = (state_q == ST_IDLE);
  assign load_mem  = idle && start && !acc_mode;
  assign load_acc  = idle && start && acc_mode;
  assign rd_cyc    = (state_q == ST_READ);
  assign echo_cyc  = (state_q == ST_ECHO);
  assign final_cyc = (state_q == ST_FINAL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done    <= 1'b0;
    end else begin
      done <= load_acc || final_cyc;
      unique case (state_q)
        ST_IDLE:  if (load_mem) state_q <= ST_READ;
        ST_READ:  state_q <= ST_ECHO;
        ST_ECHO:  state_q <= ST_FINAL;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rmw_seq.sv
module rmw_seq
  import rmw_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        op,
  input  logic              acc_mode,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] acc_in,
  input  logic              carry_in,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_we,
  output logic              bus_re,
  output logic [DATA_W-1:0] acc_out,
  output logic              busy,
  output logic              done,
  output logic              flag_c,
  output logic              flag_z,
  output logic              flag_n
);
  logic idle, load_mem, load_acc, rd_cyc, echo_cyc, final_cyc;
  logic [ADDR_W-1:0] addr_q;
  rmw_op_e           op_q;
  logic              cin_q;
  logic [DATA_W-1:0] orig_q;

  rmw_op_e           alu_op;
  logic [DATA_W-1:0] alu_in, alu_res;
  logic              alu_cin, alu_cout, alu_zero, alu_neg;

  rmw_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .acc_mode  (acc_mode),
    .idle      (idle),
    .load_mem  (load_mem),
    .load_acc  (load_acc),
    .rd_cyc    (rd_cyc),
    .echo_cyc  (echo_cyc),
    .final_cyc (final_cyc),
    .done      (done)
  );

  // While idle the ALU serves the accumulator form; otherwise the latched request.
  assign alu_op  = idle ? rmw_op_e'(op) : op_q;
  assign alu_in  = idle ? acc_in : orig_q;
  assign alu_cin = idle ? carry_in : cin_q;

  rmw_alu #(.DATA_W(DATA_W)) u_alu (
    .op   (alu_op),
    .val  (alu_in),
    .cin  (alu_cin),
    .res  (alu_res),
    .cout (alu_cout),
    .zero (alu_zero),
    .neg  (alu_neg)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      op_q    <= OP_INC;
      cin_q   <= 1'b0;
      orig_q  <= '0;
      acc_out <= '0;
      flag_c  <= 1'b0;
      flag_z  <= 1'b0;
      flag_n  <= 1'b0;
    end else begin
      if (load_mem) begin
        addr_q <= addr_in;
        op_q   <= rmw_op_e'(op);
        cin_q  <= carry_in;
      end
      if (rd_cyc) orig_q <= bus_rdata;
      if (load_acc) acc_out <= alu_res;
      if (load_acc || final_cyc) begin
        flag_c <= alu_cout;
        flag_z <= alu_zero;
        flag_n <= alu_neg;
      end
    end
  end

  assign busy      = !idle;
  assign bus_addr  = addr_q;
  assign bus_re    = rd_cyc;
  assign bus_we    = echo_cyc || final_cyc;
  assign bus_wdata = final_cyc ? alu_res : (echo_cyc ? orig_q : '0);
endmodule

// File: rtl/rmw_seq_chk.sv
module rmw_seq_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              acc_mode,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_we,
  input logic              bus_re,
  input logic              busy,
  input logic              done,
  input logic              flag_c,
  input logic              flag_z,
  input logic              flag_n
);
  assert_echo_original_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_re |=> bus_we && $stable(bus_addr) && bus_wdata == $past(bus_rdata));

  assert_final_follows_echo_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && $past(bus_re)) |=> bus_we && $stable(bus_addr));

  assert_no_read_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_re));

  assert_done_after_final_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !$past(bus_re)) |=> done && !busy);

  assert_flags_from_result_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !$past(bus_re)) |=> flag_z == ($past(bus_wdata) == '0)
                                    && flag_n == $past(bus_wdata[DATA_W-1]));

  assert_acc_off_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && acc_mode && !busy) |=> done && !bus_we && !bus_re && !busy);

  assert_flags_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable({flag_c, flag_z, flag_n}));
endmodule

bind rmw_seq rmw_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .acc_mode  (acc_mode),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .bus_wdata (bus_wdata),
  .bus_we    (bus_we),
  .bus_re    (bus_re),
  .busy      (busy),
  .done      (done),
  .flag_c    (flag_c),
  .flag_z    (flag_z),
  .flag_n    (flag_n)
);

// File: tb/sim_rmw_seq.sv
`timescale 1ns/1ps
module sim_rmw_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = 3'd0;
  logic        acc_mode = 1'b0;
  logic [15:0] addr_in = '0;
  logic [7:0]  acc_in = '0;
  logic        carry_in = 1'b0;
  logic [15:0] bus_addr;
  logic [7:0]  bus_rdata, bus_wdata, acc_out;
  logic        bus_we, bus_re, busy, done, flag_c, flag_z, flag_n;

  logic [7:0]  mem [256];
  logic        pre_we = 1'b0;
  logic [7:0]  pre_addr = '0, pre_data = '0;
  int          tests = 0, fails = 0;
  bit          finished = 1'b0;

  always #10 clk = ~clk;

  rmw_seq u0 (.*);

  assign bus_rdata = mem[bus_addr[7:0]];
  always @(posedge clk) begin
    if (bus_we) mem[bus_addr[7:0]] <= bus_wdata;
    else if (pre_we) mem[pre_addr] <= pre_data;
  end

  // Per-clock comparison: the bus never reads and writes in the same cycle (R1).
  always @(negedge clk) if (rst_n && !finished) begin
    tests++;
    if (bus_we && bus_re) begin
      fails++;
      $display("FAIL R1 read+write together act=%b%b exp=0", bus_we, bus_re);
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference: returns {carry, value}.
  function automatic logic [8:0] model(input int code, input logic [7:0] v, input logic c);
    case (code)
      0: return {c, 8'((int'(v) + 1) % 256)};
      1: return {c, 8'((int'(v) + 255) % 256)};
      2: return {v[7], 8'((int'(v) * 2) % 256)};
      3: return {v[0], 8'(int'(v) / 2)};
      4: return {v[7], 8'((int'(v) * 2) % 256 + int'(c))};
      5: return {v[0], 8'(int'(v) / 2 + (c ? 128 : 0))};
      default: return {c, v};
    endcase
  endfunction

  function automatic string optag(input int code);
    case (code)
      0, 1: return "R4";
      2, 3: return "R5";
      4, 5: return "R6";
      default: return "R9";
    endcase
  endfunction

  task automatic run_mem(input int code, input logic [15:0] a, input logic [7:0] init,
                         input logic c, input bit disturb);
    logic [8:0] e;
    logic [7:0] acc_before;
    e = model(code, init, c);
    acc_before = acc_out;
    pre_we = 1'b1; pre_addr = a[7:0]; pre_data = init;
    @(negedge clk);
    pre_we = 1'b0;
    op = 3'(code); addr_in = a; carry_in = c; acc_mode = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(bus_re && !bus_we && bus_addr == a && busy, "R1 read cycle", {bus_re, bus_we, bus_addr}, {2'b10, a});
    if (disturb) begin
      start = 1'b1; op = 3'(7 - code); addr_in = ~a; carry_in = ~c; acc_mode = 1'b1;
    end
    @(negedge clk);
    check(bus_we && bus_wdata == init && bus_addr == a, "R1 echo write", bus_wdata, init);
    if (disturb) check(busy, "R8 still busy", busy, 1);
    @(negedge clk);
    start = 1'b0; acc_mode = 1'b0;
    check(bus_we && bus_wdata == e[7:0] && bus_addr == a, {optag(code), " final write"}, bus_wdata, e[7:0]);
    @(negedge clk);
    check(done && !busy && !bus_we && !bus_re, "R2 done pulse", {done, busy, bus_we, bus_re}, 4'b1000);
    check(flag_c == e[8], {optag(code), " carry"}, flag_c, e[8]);
    check(flag_z == (e[7:0] == 0) && flag_n == e[7], "R3 zero/neg", {flag_z, flag_n}, {e[7:0] == 0, e[7]});
    check(mem[a[7:0]] == e[7:0], {optag(code), " memory"}, mem[a[7:0]], e[7:0]);
    if (disturb) check(acc_out == acc_before, "R8 acc untouched", acc_out, acc_before);
    @(negedge clk);
    check(!done && flag_c == e[8] && flag_z == (e[7:0] == 0), "R2/R10 done drops, flags hold",
          {done, flag_c}, {1'b0, e[8]});
  endtask

  task automatic run_acc(input int code, input logic [7:0] v, input logic c);
    logic [8:0] e;
    e = model(code, v, c);
    op = 3'(code); acc_in = v; carry_in = c; acc_mode = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0; acc_mode = 1'b0;
    check(done && !busy && !bus_we && !bus_re, "R7 no bus", {done, busy, bus_we, bus_re}, 4'b1000);
    check(acc_out == e[7:0] && flag_c == e[8], "R7 acc result", {flag_c, acc_out}, e);
    check(flag_z == (e[7:0] == 0) && flag_n == e[7], "R7 R3 acc flags", {flag_z, flag_n}, {e[7:0] == 0, e[7]});
    @(negedge clk);
    check(!done && acc_out == e[7:0], "R10 acc holds", acc_out, e[7:0]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !bus_we && !bus_re && acc_out == 0 && !flag_c && !flag_z && !flag_n,
          "R10 reset state", {busy, done, bus_we, bus_re, flag_c, flag_z, flag_n}, 0);
    run_mem(0, 16'h1210, 8'h7F, 1'b0, 1'b0);
    run_mem(0, 16'h1211, 8'hFF, 1'b1, 1'b0);
    run_mem(1, 16'h1212, 8'h00, 1'b0, 1'b0);
    run_mem(1, 16'h1213, 8'h01, 1'b1, 1'b0);
    run_mem(2, 16'h1214, 8'h81, 1'b0, 1'b0);
    run_mem(3, 16'h1215, 8'h01, 1'b1, 1'b0);
    run_mem(4, 16'h1216, 8'h80, 1'b1, 1'b0);
    run_mem(4, 16'h1217, 8'h40, 1'b0, 1'b0);
    run_mem(5, 16'h1218, 8'h01, 1'b1, 1'b0);
    run_mem(5, 16'h1219, 8'h02, 1'b0, 1'b0);
    run_mem(6, 16'h121A, 8'h00, 1'b1, 1'b0);
    run_mem(7, 16'h121B, 8'h90, 1'b0, 1'b0);
    run_acc(2, 8'h40, 1'b1);
    run_acc(5, 8'h01, 1'b0);
    run_mem(3, 16'h121C, 8'hA6, 1'b1, 1'b1);
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule